// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block moves 36-bit words from a producer clocked by `clk_a` to a consumer clocked by `clk_b`. The two clocks may be unrelated. A write on port A takes place only when that port's qualifiers all select a FIFO write. A read on port B takes place only when its qualifiers select a FIFO read and the port shows that data is waiting. Pointers cross between the domains as Gray codes through a chain of flip-flops (two by default). A flag therefore asserts in its own domain on the same edge that causes it, and deasserts only after the opposite pointer has passed through the synchronizer.

While `rst_n` is low, the block samples and holds the operating mode and the two threshold offsets. In standard mode a read request loads the next stored word into the output register. In fall-through mode the oldest word moves into the output register on its own, and `b_avail` then means that `b_data` holds a valid word. A read request consumes that word. The output register is not counted as FIFO storage. In fall-through mode the block can therefore hold one word more than the memory depth.

Top module: `dcf_fifo`

## Requirements
- R1: A word is accepted from port A only in a `clk_a` cycle with `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mb`=0 and `a_room`=1. Any other combination stores nothing.
- R2: In standard mode a read is performed only in a `clk_b` cycle with `b_cs_n`=0, `b_wr`=0, `b_en`=1, `b_mb`=0 and `b_avail`=1. It loads the oldest stored word into `b_data` on that edge. With any other combination, `b_data` holds.
- R3: In fall-through mode, the first word written into an empty FIFO appears on `b_data` with `b_avail`=1 and no read request. The word stays until a qualified read consumes it.
- R4: In fall-through mode the word held in `b_data` is excluded from the stored-word count. `a_room` therefore stays 1 after DEPTH writes and drops to 0 after DEPTH+1 writes with no reads.
- R5: `b_ae_n` is 0 while the memory holds 0 to X words and 1 while it holds X+1 or more, where X is the `ae_offset_i` value sampled during reset.
- R6: `a_af_n` is 0 while the memory holds DEPTH−Y to DEPTH words and 1 below that, where Y is the `af_offset_i` value sampled during reset.
- R7: `a_room` is 0 only when DEPTH words are stored. A write attempted while it is 0 is discarded.
- R8: A read request while `b_avail`=0 has no effect: `b_data` holds and no word is lost.
- R9: After reset, `a_room`=1, `a_af_n`=1, `b_avail`=0, `b_ae_n`=0 and `b_data`=0.
- R10: Words leave port B in the order they were accepted on port A, including while both ports are active at the same time.
- R11: The mode is taken only during reset (`fwft_mode_i`=1 selects fall-through). Changing `fwft_mode_i` afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| fwft_mode_i | input | 1 | Mode sampled during reset: 1 = fall-through, 0 = standard |
| ae_offset_i | input | AW | Almost-empty offset X, sampled during reset |
| af_offset_i | input | AW | Almost-full offset Y, sampled during reset |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_mb | input | 1 | Port A side-channel select; must be 0 for FIFO access |
| a_data | input | 36 | Write data |
| a_room | output | 1 | 1 = space available (0 = full), `clk_a` domain |
| a_af_n | output | 1 | 0 = almost full, `clk_a` domain |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr | input | 1 | Port B direction, 0 = read |
| b_en | input | 1 | Port B enable |
| b_mb | input | 1 | Port B side-channel select; must be 0 for FIFO access |
| b_data | output | 36 | Output register |
| b_avail | output | 1 | Standard: data stored; fall-through: `b_data` valid |
| b_ae_n | output | 1 | 0 = almost empty, `clk_b` domain |

## Verification
The hardest state to reach is a full FIFO in fall-through mode, where the memory holds DEPTH words and one more sits in the output register. The stimulus writes DEPTH words with no read. It waits long enough for the first word's removal to cross back to the write side, checks that there is still room, and then writes once more. The almost-full and almost-empty thresholds are approached one word at a time, with a pause after each word so that both synchronizers settle before the flags are sampled. A concurrent phase runs the writer and the reader in parallel on clocks with an 8:5 period ratio, so pointer crossings land at many different phases.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int WORD_W = 36;
  typedef logic [15:0] ptr_t;

  function automatic ptr_t gray_to_bin(ptr_t g);
    ptr_t b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // words between two wrapping pointers of pw bits
  function automatic ptr_t words_used(ptr_t head, ptr_t tail, int unsigned pw);
    ptr_t mask;
    mask = ptr_t'((32'd1 << pw) - 32'd1);
    return (head - tail) & mask;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_st
    logic [W-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else        r <= g_st[i-1].r;
      end
    end
  end
  assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DEPTH = 2048,
  parameter int W     = 36,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_w,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ram [DEPTH];
  always_ff @(posedge clk_w) begin
    if (we) ram[waddr] <= wdata;
  end
  assign rdata = ram[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] af_off_i,
  input  logic [PW-1:0] rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          room,
  output logic          af_n
);
  logic [PW-1:0] wbin, wbin_nx;
  logic [AW-1:0] af_off_q;
  ptr_t          rbin_s, used_nx, used_cur;

  assign rbin_s   = gray_to_bin(ptr_t'(rgray_s));
  assign we       = req & room;
  assign wbin_nx  = wbin + PW'(we);
  assign used_nx  = words_used(ptr_t'(wbin_nx), rbin_s, PW);
  assign used_cur = words_used(ptr_t'(wbin), rbin_s, PW);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      room     <= 1'b1;
      af_n     <= 1'b1;
      af_off_q <= af_off_i;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      room  <= (used_nx != ptr_t'(DEPTH));
      af_n  <= (used_nx < (ptr_t'(DEPTH) - ptr_t'(af_off_q)));
    end
  end

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    used_cur <= ptr_t'(DEPTH));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !room |=> (wbin == $past(wbin)));
  p_write_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (wbin == $past(wbin) + PW'(1)));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int W     = 36,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          fwft_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [PW-1:0] wgray_s,
  input  logic [W-1:0]  rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [W-1:0]  dout,
  output logic          avail,
  output logic          ae_n
);
  logic          fwft_q;
  logic [AW-1:0] ae_off_q;
  logic [PW-1:0] rbin, rbin_nx;
  ptr_t          wbin_s, used, used_nx;
  logic          std_pop, ff_load, ff_take, mem_pop, avail_nx;

  assign wbin_s  = gray_to_bin(ptr_t'(wgray_s));
  assign used    = words_used(wbin_s, ptr_t'(rbin), PW);
  assign std_pop = req & avail;
  assign ff_take = req & avail;
  assign ff_load = (used != '0) & (~avail | req);
  assign mem_pop = fwft_q ? ff_load : std_pop;
  assign rbin_nx = rbin + PW'(mem_pop);
  assign used_nx = words_used(wbin_s, ptr_t'(rbin_nx), PW);
  assign raddr   = rbin[AW-1:0];

  always_comb begin
    if (fwft_q) avail_nx = ff_load ? 1'b1 : (ff_take ? 1'b0 : avail);
    else        avail_nx = (used_nx != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      dout     <= '0;
      avail    <= 1'b0;
      ae_n     <= 1'b0;
      fwft_q   <= fwft_i;
      ae_off_q <= ae_off_i;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      avail <= avail_nx;
      ae_n  <= (used_nx > ptr_t'(ae_off_q));
      if (mem_pop) dout <= rdata;
    end
  end

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pop |-> (used != '0));
  p_fall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft_q && avail && !req) |=> (avail && $stable(dout)));
  p_std_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft_q && !req) |=> $stable(dout));
  p_ae_implies_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ae_n |-> avail);
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DEPTH       = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1,
  localparam int W          = dcf_pkg::WORD_W
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          fwft_mode_i,
  input  logic [AW-1:0] ae_offset_i,
  input  logic [AW-1:0] af_offset_i,
  input  logic          a_cs_n,
  input  logic          a_wr,
  input  logic          a_en,
  input  logic          a_mb,
  input  logic [W-1:0]  a_data,
  output logic          a_room,
  output logic          a_af_n,
  input  logic          b_cs_n,
  input  logic          b_wr,
  input  logic          b_en,
  input  logic          b_mb,
  output logic [W-1:0]  b_data,
  output logic          b_avail,
  output logic          b_ae_n
);
  logic          wr_req, rd_req, we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [W-1:0]  rdata;

  assign wr_req = ~a_cs_n &  a_wr & a_en & ~a_mb;
  assign rd_req = ~b_cs_n & ~b_wr & b_en & ~b_mb;

  dcf_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
    .clk_w(clk_a), .we(we), .waddr(waddr), .wdata(a_data),
    .raddr(raddr), .rdata(rdata));

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(clk_a), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(clk_b), .rst_n(rst_n), .d(wgray), .q(wgray_s));

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk_a), .rst_n(rst_n), .req(wr_req), .af_off_i(af_offset_i),
    .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
    .room(a_room), .af_n(a_af_n));

  dcf_rd_ctl #(.DEPTH(DEPTH), .W(W)) u_rd (
    .clk(clk_b), .rst_n(rst_n), .req(rd_req), .fwft_i(fwft_mode_i),
    .ae_off_i(ae_offset_i), .wgray_s(wgray_s), .rdata(rdata),
    .raddr(raddr), .rgray(rgray), .dout(b_data), .avail(b_avail),
    .ae_n(b_ae_n));

  p_write_qual_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
    we |-> (!a_cs_n && a_wr && a_en && !a_mb && a_room));
  p_af_before_full_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_room |-> !a_af_n);
endmodule

// File: tb/dcf_fifo_tb_top.sv
`timescale 1ns/1ps
module dcf_fifo_tb_top;
  localparam int DEPTH = 2048;
  localparam int AW    = $clog2(DEPTH);
  localparam int XOFF  = 4;
  localparam int YOFF  = 8;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic fwft_mode_i = 0;
  logic [AW-1:0] ae_offset_i = AW'(XOFF), af_offset_i = AW'(YOFF);
  logic a_cs_n = 1, a_wr = 0, a_en = 0, a_mb = 0;
  logic [35:0] a_data = '0;
  logic b_cs_n = 1, b_wr = 1, b_en = 0, b_mb = 0;
  logic a_room, a_af_n, b_avail, b_ae_n;
  logic [35:0] b_data;

  always #2.5 clk_a = ~clk_a;
  always #4   clk_b = ~clk_b;

  dcf_fifo #(.DEPTH(DEPTH)) dut_i (.*);

  int tests = 0, fails = 0;
  bit fwft = 0, done = 0;
  logic [35:0] sb[$];
  logic [35:0] seed = 36'h1_2345_0000;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(posedge clk_a);
    repeat (10) @(posedge clk_b);
    @(negedge clk_b);
  endtask

  task automatic do_reset(bit mode);
    rst_n = 0; fwft_mode_i = mode; fwft = mode; sb.delete();
    repeat (6) @(posedge clk_b);
    @(negedge clk_b) rst_n = 1;
    settle();
  endtask

  // driver: scoreboard push happens only for writes the bench expects to land
  task automatic wr_any(bit cs_n, bit wr, bit en, bit mb, logic [35:0] d, bit expect_store);
    @(negedge clk_a);
    if (expect_store && a_room) sb.push_back(d);
    a_cs_n = cs_n; a_wr = wr; a_en = en; a_mb = mb; a_data = d;
    @(negedge clk_a);
    a_cs_n = 1; a_en = 0;
  endtask

  task automatic put();
    seed = seed + 36'h0_0001_0003;
    wr_any(0, 1, 1, 0, seed, 1);
  endtask

  // monitor: consume one word from port B and compare with scoreboard head
  task automatic take(string req);
    logic [35:0] exp;
    @(negedge clk_b);
    while (!b_avail) @(negedge clk_b);
    exp = (sb.size() > 0) ? sb.pop_front() : 36'hX_XXXX_XXXX;
    if (fwft) chk(b_data === exp, req, b_data, exp);
    b_cs_n = 0; b_wr = 0; b_en = 1; b_mb = 0;
    @(negedge clk_b);
    b_cs_n = 1; b_en = 0;
    if (!fwft) chk(b_data === exp, req, b_data, exp);
  endtask

  initial begin
    #800us;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [35:0] hold;
    // ---------- standard mode ----------
    do_reset(0);
    chk(a_room == 1, "R9", a_room, 1);
    chk(a_af_n == 1, "R9", a_af_n, 1);
    chk(b_avail == 0, "R9", b_avail, 0);
    chk(b_ae_n == 0, "R9", b_ae_n, 0);
    chk(b_data == 0, "R9", b_data, 0);

    // R1: unqualified writes store nothing
    wr_any(1, 1, 1, 0, 36'hA1, 0);
    wr_any(0, 0, 1, 0, 36'hA2, 0);
    wr_any(0, 1, 0, 0, 36'hA3, 0);
    wr_any(0, 1, 1, 1, 36'hA4, 0);
    settle();
    chk(b_avail == 0, "R1", b_avail, 0);
    wr_any(0, 1, 1, 0, 36'h5_0000_00AB, 1);
    settle();
    chk(b_avail == 1, "R1", b_avail, 1);
    chk(b_data == 0, "R2", b_data, 0);

    // R2: unqualified reads leave data and flag
    foreach (hold[i]) if (i < 4) begin
      @(negedge clk_b);
      b_cs_n = (i == 0); b_wr = (i == 1); b_en = (i != 2); b_mb = (i == 3);
      @(negedge clk_b);
      b_cs_n = 1; b_en = 0; b_mb = 0; b_wr = 1;
    end
    settle();
    chk(b_data == 0, "R2", b_data, 0);
    chk(b_avail == 1, "R2", b_avail, 1);
    take("R2");

    // R8: read while empty is ignored
    settle();
    hold = b_data;
    @(negedge clk_b); b_cs_n = 0; b_wr = 0; b_en = 1;
    repeat (5) @(negedge clk_b);
    b_cs_n = 1; b_en = 0;
    chk(b_data == hold, "R8", b_data, hold);
    chk(b_avail == 0, "R8", b_avail, 0);
    put(); take("R8");

    // R5: almost-empty threshold
    for (int i = 0; i < XOFF; i++) put();
    settle();
    chk(b_ae_n == 0, "R5", b_ae_n, 0);
    put(); settle();
    chk(b_ae_n == 1, "R5", b_ae_n, 1);
    for (int i = 0; i <= XOFF; i++) take("R10");

    // R6/R7: almost-full and full
    for (int i = 0; i < DEPTH - YOFF - 1; i++) put();
    settle();
    chk(a_af_n == 1, "R6", a_af_n, 1);
    put(); settle();
    chk(a_af_n == 0, "R6", a_af_n, 0);
    chk(a_room == 1, "R7", a_room, 1);
    for (int i = 0; i < YOFF; i++) put();
    settle();
    chk(a_room == 0, "R7", a_room, 0);
    wr_any(0, 1, 1, 0, 36'hD_EAD0_0000, 1);  // discarded, not pushed
    chk(sb.size() == DEPTH, "R7", sb.size(), DEPTH);
    for (int i = 0; i < DEPTH; i++) take("R7");
    settle();
    chk(b_avail == 0, "R7", b_avail, 0);
    chk(a_room == 1 && a_af_n == 1, "R6", {a_room, a_af_n}, 2'b11);

    // R10: concurrent traffic
    fork
      for (int i = 0; i < 300; i++) put();
      for (int i = 0; i < 300; i++) take("R10");
    join
    settle();
    chk(b_avail == 0, "R10", b_avail, 0);

    // R11: mode pin ignored after reset
    fwft_mode_i = 1;
    put(); settle();
    chk(b_avail == 1, "R11", b_avail, 1);
    chk(b_data == sb[0] - 36'h0_0001_0003, "R11", b_data, sb[0] - 36'h0_0001_0003);
    take("R11");

    // ---------- fall-through mode ----------
    do_reset(1);
    chk(b_avail == 0 && b_data == 0, "R9", {b_avail, b_data}, 0);
    put(); settle();
    chk(b_avail == 1, "R3", b_avail, 1);
    chk(b_data == sb[0], "R3", b_data, sb[0]);
    chk(b_ae_n == 0, "R4", b_ae_n, 0);
    for (int i = 0; i < XOFF; i++) put();
    settle();
    chk(b_ae_n == 0, "R5", b_ae_n, 0);
    put(); settle();
    chk(b_ae_n == 1, "R5", b_ae_n, 1);
    for (int i = 0; i < XOFF + 2; i++) take("R3");
    settle();
    chk(b_avail == 0, "R3", b_avail, 0);

    // R4: output word not counted
    for (int i = 0; i < DEPTH; i++) put();
    settle();
    chk(a_room == 1, "R4", a_room, 1);
    put(); settle();
    chk(a_room == 0, "R4", a_room, 0);
    chk(sb.size() == DEPTH + 1, "R4", sb.size(), DEPTH + 1);
    for (int i = 0; i < DEPTH + 1; i++) take("R4");
    settle();
    chk(b_avail == 0, "R4", b_avail, 0);

    fork
      for (int i = 0; i < 200; i++) put();
      for (int i = 0; i < 200; i++) take("R10");
    join

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule